// File: doc/BRIEF.md
# Write Buffer with Read-Miss Bypass

This block sits between a write-through cache and the next memory level. Word writes from the cache are collected into a small queue of block-sized entries. The queue drains to memory in the background, oldest entry first. A write whose block is already held in an entry is folded into that entry under a per-byte mask, so it does not take a new slot. The cache stalls only when every slot is taken and the write cannot be folded.

A read miss is checked against all live entries before it goes to memory. If no entry holds its block, the read jumps ahead of the queued writes. If an entry does hold the block, the queue drains until that entry is gone, and then the read is issued. A single memory port carries both block reads and masked block writes. A drain presented on that port is never withdrawn, and a pending read only wins the port between drains.

Top module: `wbuf_rdbypass`

## Requirements
- R1: After reset the queue is empty, `wr_ready` is 1, and neither `mem_req_valid` nor `rd_resp_valid` is asserted.
- R2: The write address is a byte address. Block number = `wr_addr[AW-1:4]` and word index = `wr_addr[3:2]`, with the low two bits zero. A write is accepted into a free slot when no entry can absorb it. `wr_ready` is 0 only when all 4 slots are live and no mergeable entry matches, or when the write's block equals that of a read miss being held on `rd_valid`.
- R3: A write to a block held in a live, non-draining entry is merged into that entry. Bytes with `wr_be` set overwrite older bytes, and the entry's mask gains those bytes.
- R4: Entries leave in allocation order, one memory write per entry. `mem_req_wmask` bit 4*w+b covers byte b of word w and equals the union of byte enables the entry received. Only masked bytes may change memory.
- R5: A read miss (`rd_addr` block-aligned, low four bits zero) whose block matches no live entry is sent to memory before any queued write that has not yet been presented.
- R6: A read miss whose block matches a live entry waits until every entry up to and including the matching one has drained, then goes to memory.
- R7: Once a drain is presented (`mem_req_valid` and `mem_req_we`), the request and its address, data and mask hold unchanged until `mem_req_ready` accepts it.
- R8: `rd_resp_valid` pulses in the same cycle as `mem_rsp_valid` for the outstanding read, and `rd_resp_data` carries the returned block (word w in bits 32w+31:32w).
- R9: The entry being drained absorbs no merges. A write to its block takes a new slot, or stalls if none is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache write request |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_addr | input | AW | Byte address of the written word |
| wr_data | input | DW | Write data word |
| wr_be | input | DW/8 | Byte enables of the word |
| rd_valid | input | 1 | Read miss pending; held until the response cycle |
| rd_addr | input | AW | Block-aligned read miss address |
| rd_resp_valid | output | 1 | Read miss data returned |
| rd_resp_data | output | WORDS*DW | Returned block |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = block write (drain), 0 = block read |
| mem_req_addr | output | AW | Block-aligned request address |
| mem_req_wdata | output | WORDS*DW | Drain data |
| mem_req_wmask | output | WORDS*DW/8 | Drain byte mask |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | WORDS*DW | Memory read data |

## Verification
A write is taken at the rising edge where `wr_valid` and `wr_ready` are both high. The queue state it changes is visible from the next cycle, so a stall or merge probe drives the address at the falling edge and reads `wr_ready` just after it. A drain or read reaches the memory port one cycle after the arbiter is idle and sees work. The bench's memory model therefore samples request handshakes after its own falling-edge update and logs them in order, and R4 to R7 are judged from that log. Read data is due in the cycle the model raises `mem_rsp_valid`, three cycles after the read is accepted, and is compared there with a reference image that applied every accepted write at once.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE   = 2'd0,
      ARB_DRAIN  = 2'd1,
      ARB_RDREQ  = 2'd2,
      ARB_RDWAIT = 2'd3
   } arb_state_e;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int ENTRIES = 4,
   parameter int BW      = 28
) (
   input  logic [BW-1:0]         key,
   input  logic [ENTRIES-1:0]    vld,
   input  logic [ENTRIES*BW-1:0] blks,
   input  logic [ENTRIES-1:0]    skip,
   output logic [ENTRIES-1:0]    hit
);
   // one comparator per slot, all in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit[g] = vld[g] && !skip[g] && (blks[g*BW +: BW] == key);
   end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int ENTRIES = 4,
   parameter int BW      = 28,
   parameter int DW      = 32,
   parameter int WORDS   = 4,
   localparam int BYTES  = DW / 8,
   localparam int WS     = $clog2(WORDS),
   localparam int PTRW   = $clog2(ENTRIES),
   localparam int CW     = PTRW + 1,
   localparam int BLKW   = WORDS * DW,
   localparam int BLKB   = WORDS * BYTES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [BW-1:0]         wr_blk,
   input  logic [WS-1:0]         wr_word,
   input  logic [DW-1:0]         wr_data,
   input  logic [BYTES-1:0]      wr_be,
   input  logic [ENTRIES-1:0]    merge_hit,
   input  logic                  pop,
   output logic [ENTRIES-1:0]    vld,
   output logic [ENTRIES*BW-1:0] blks,
   output logic [PTRW-1:0]       head_idx,
   output logic [BW-1:0]         head_blk,
   output logic [BLKW-1:0]       head_data,
   output logic [BLKB-1:0]       head_mask,
   output logic                  full,
   output logic                  empty
);
   logic [BW-1:0]   ent_blk  [ENTRIES];
   logic [BLKW-1:0] ent_data [ENTRIES];
   logic [BLKB-1:0] ent_mask [ENTRIES];
   logic [ENTRIES-1:0] ent_vld;
   logic [PTRW-1:0] head, tail, tgt, sel;
   logic [CW-1:0]   count;
   logic            merge, alloc;
   logic [BLKB-1:0] lane_mask;
   logic [BLKW-1:0] lane_data, bit_mask;

   assign tail  = head + count[PTRW-1:0];
   assign full  = (count == CW'(ENTRIES));
   assign empty = (count == '0);
   assign merge = |merge_hit;
   assign alloc = wr_en && !merge;
   assign sel   = merge ? tgt : tail;

   always_comb begin
      tgt = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (merge_hit[e]) tgt = PTRW'(e);
   end

   // place the word and its enables at their lane in the block
   always_comb begin
      lane_mask = '0;
      lane_data = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (wr_word == WS'(w)) begin
            lane_mask[w*BYTES +: BYTES] = wr_be;
            lane_data[w*DW +: DW]       = wr_data;
         end
      end
      for (int k = 0; k < BLKB; k++)
         bit_mask[k*8 +: 8] = {8{lane_mask[k]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld <= '0;
         head    <= '0;
         count   <= '0;
      end else begin
         if (pop) begin
            ent_vld[head] <= 1'b0;
            head          <= head + 1'b1;
         end
         if (wr_en) begin
            ent_data[sel] <= (ent_data[sel] & ~bit_mask) | (lane_data & bit_mask);
            ent_mask[sel] <= (merge ? ent_mask[sel] : '0) | lane_mask;
            if (!merge) begin
               ent_vld[tail] <= 1'b1;
               ent_blk[tail] <= wr_blk;
            end
         end
         if (alloc && !pop)      count <= count + 1'b1;
         else if (!alloc && pop) count <= count - 1'b1;
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
      assign blks[g*BW +: BW] = ent_blk[g];
   end

   assign vld       = ent_vld;
   assign head_idx  = head;
   assign head_blk  = ent_blk[head];
   assign head_data = ent_data[head];
   assign head_mask = ent_mask[head];

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(ENTRIES));
   a_r2_alloc_room: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full);
   a_r3_single_merge: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(merge_hit));
   a_r4_pop_live: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> ent_vld[head]);
   a_r4_count_tracks_live: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ent_vld) == int'(count));
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
   import wbuf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_valid,
   input  logic rd_conflict,
   input  logic empty,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   output logic mem_req_valid,
   output logic mem_req_we,
   output logic pop,
   output logic draining,
   output logic rd_resp_valid
);
   arb_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ARB_IDLE: begin
            // a clear read wins over the next drain
            if (rd_valid && !rd_conflict) state_nx = ARB_RDREQ;
            else if (!empty)              state_nx = ARB_DRAIN;
         end
         ARB_DRAIN:  if (mem_req_ready) state_nx = ARB_IDLE;
         ARB_RDREQ:  if (mem_req_ready) state_nx = ARB_RDWAIT;
         ARB_RDWAIT: if (mem_rsp_valid) state_nx = ARB_IDLE;
         default:    state_nx = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ARB_IDLE;
      else        state <= state_nx;
   end

   assign mem_req_valid = (state == ARB_DRAIN) || (state == ARB_RDREQ);
   assign mem_req_we    = (state == ARB_DRAIN);
   assign draining      = (state == ARB_DRAIN);
   assign pop           = (state == ARB_DRAIN) && mem_req_ready;
   assign rd_resp_valid = (state == ARB_RDWAIT) && mem_rsp_valid;

   a_r7_drain_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we && !mem_req_ready) |=> (mem_req_valid && mem_req_we));
   a_r4_no_empty_drain: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_we |-> !empty);
   a_r8_resp_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_valid |-> rd_valid);
endmodule

// File: rtl/wbuf_rdbypass.sv
module wbuf_rdbypass #(
   parameter int AW      = 32,
   parameter int DW      = 32,
   parameter int WORDS   = 4,
   parameter int ENTRIES = 4,
   localparam int BYTES  = DW / 8,
   localparam int LB     = $clog2(BYTES),
   localparam int WS     = $clog2(WORDS),
   localparam int OFF    = LB + WS,
   localparam int BW     = AW - OFF,
   localparam int PTRW   = $clog2(ENTRIES),
   localparam int BLKW   = WORDS * DW,
   localparam int BLKB   = WORDS * BYTES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_valid,
   output logic            wr_ready,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [BYTES-1:0] wr_be,
   input  logic            rd_valid,
   input  logic [AW-1:0]   rd_addr,
   output logic            rd_resp_valid,
   output logic [BLKW-1:0] rd_resp_data,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic            mem_req_we,
   output logic [AW-1:0]   mem_req_addr,
   output logic [BLKW-1:0] mem_req_wdata,
   output logic [BLKB-1:0] mem_req_wmask,
   input  logic            mem_rsp_valid,
   input  logic [BLKW-1:0] mem_rsp_data
);
   // elaboration-time parameter checks
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (DW < 16 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power of two, at least 16");
   end
   if (AW <= OFF) begin : g_bad_aw
      $error("AW too small for the block offset");
   end

   logic [BW-1:0]         wr_blk, rd_blk;
   logic [WS-1:0]         wr_word;
   logic [ENTRIES-1:0]    vld, merge_hit, rd_hit, drain_skip;
   logic [ENTRIES*BW-1:0] blks;
   logic [PTRW-1:0]       head_idx;
   logic [BW-1:0]         head_blk;
   logic [BLKW-1:0]       head_data;
   logic [BLKB-1:0]       head_mask;
   logic                  full, empty, pop, draining, wr_fire, rd_block_hazard;

   assign wr_blk  = wr_addr[AW-1:OFF];
   assign wr_word = wr_addr[OFF-1:LB];
   assign rd_blk  = rd_addr[AW-1:OFF];

   assign drain_skip      = draining ? (ENTRIES'(1) << head_idx) : '0;
   assign rd_block_hazard = rd_valid && (rd_blk == wr_blk);
   assign wr_ready        = ((|merge_hit) || !full) && !rd_block_hazard;
   assign wr_fire         = wr_valid && wr_ready;

   wbuf_match #(.ENTRIES(ENTRIES), .BW(BW)) u_wr_match (
      .key (wr_blk),
      .vld (vld),
      .blks(blks),
      .skip(drain_skip),
      .hit (merge_hit)
   );

   wbuf_match #(.ENTRIES(ENTRIES), .BW(BW)) u_rd_match (
      .key (rd_blk),
      .vld (vld),
      .blks(blks),
      .skip('0),
      .hit (rd_hit)
   );

   wbuf_store #(.ENTRIES(ENTRIES), .BW(BW), .DW(DW), .WORDS(WORDS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire),
      .wr_blk   (wr_blk),
      .wr_word  (wr_word),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .merge_hit(merge_hit),
      .pop      (pop),
      .vld      (vld),
      .blks     (blks),
      .head_idx (head_idx),
      .head_blk (head_blk),
      .head_data(head_data),
      .head_mask(head_mask),
      .full     (full),
      .empty    (empty)
   );

   wbuf_arb u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_valid     (rd_valid),
      .rd_conflict  (|rd_hit),
      .empty        (empty),
      .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_req_valid(mem_req_valid),
      .mem_req_we   (mem_req_we),
      .pop          (pop),
      .draining     (draining),
      .rd_resp_valid(rd_resp_valid)
   );

   assign mem_req_addr  = {(mem_req_we ? head_blk : rd_blk), {OFF{1'b0}}};
   assign mem_req_wdata = head_data;
   assign mem_req_wmask = mem_req_we ? head_mask : '0;
   assign rd_resp_data  = mem_rsp_data;

   a_r7_drain_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we && !mem_req_ready) |=>
         ($stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_wmask)));
   a_r5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_we) |-> !(|rd_hit));
   a_r9_drain_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (draining && wr_fire) |-> !merge_hit[head_idx]);
   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[LB-1:0] == '0));
   a_r5_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_addr[OFF-1:0] == '0));
endmodule

// File: tb/wbuf_rdbypass_tb.sv
`timescale 1ns/100ps
module wbuf_rdbypass_tb;
   localparam int RLAT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic         wr_ready;
   logic [31:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   wr_be = '0;
   logic         rd_valid = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic         rd_resp_valid;
   logic [127:0] rd_resp_data;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b0;
   logic         mem_req_we;
   logic [31:0]  mem_req_addr;
   logic [127:0] mem_req_wdata;
   logic [15:0]  mem_req_wmask;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_data = '0;

   always #2.5 clk = ~clk;

   wbuf_rdbypass u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_req_wmask(mem_req_wmask),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] mw [64];
   logic [31:0] rw [64];
   logic        log_we   [64];
   int          log_blk  [64];
   logic [15:0] log_mask [64];
   int          log_n = 0;
   bit          frc = 1'b1;
   bit          frc_val = 1'b0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] ref_block(input int b);
      logic [127:0] v;
      for (int w = 0; w < 4; w++) v[w*32 +: 32] = rw[b*4 + w];
      return v;
   endfunction

   function automatic logic [127:0] mem_block(input int b);
      logic [127:0] v;
      for (int w = 0; w < 4; w++) v[w*32 +: 32] = mw[b*4 + w];
      return v;
   endfunction

   // memory model: picks ready, then logs each handshake due at the next edge
   int lat = 0;
   logic [127:0] pend = '0;
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (lat > 0) begin
            lat--;
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pend;
            end
         end
         mem_req_ready = frc ? frc_val : (($urandom % 4) != 0);
         #1;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            if (log_n < 64) begin
               log_we[log_n]   = mem_req_we;
               log_blk[log_n]  = int'(mem_req_addr[7:4]);
               log_mask[log_n] = mem_req_wmask;
               log_n++;
            end
            if (mem_req_we) begin
               for (int w = 0; w < 4; w++)
                  for (int b = 0; b < 4; b++)
                     if (mem_req_wmask[w*4+b])
                        mw[mem_req_addr[7:4]*4 + w][b*8 +: 8] = mem_req_wdata[w*32 + b*8 +: 8];
            end else begin
               pend = mem_block(int'(mem_req_addr[7:4]));
               lat  = RLAT;
            end
         end
      end
   end

   task automatic do_write(input int blk, input int word, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = 32'(blk * 16 + word * 4);
      wr_data  = d;
      wr_be    = be;
      #1;
      while (!wr_ready) begin
         @(negedge clk);
         #1;
      end
      for (int b = 0; b < 4; b++)
         if (be[b]) rw[blk*4 + word][b*8 +: 8] = d[b*8 +: 8];
      @(posedge clk);
      #1 wr_valid = 1'b0;
   endtask

   task automatic probe_write(input int blk, input int word, input bit exp, input string req);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = 32'(blk * 16 + word * 4);
      wr_be    = 4'hF;
      #1;
      check(wr_ready == exp, req, wr_ready, exp);
      wr_valid = 1'b0;
   endtask

   task automatic do_read(input int blk);
      @(negedge clk);
      rd_valid = 1'b1;
      rd_addr  = 32'(blk * 16);
      #2;
      while (!rd_resp_valid) begin
         @(negedge clk);
         #2;
      end
      // R8: data returned in the response cycle matches the reference image
      check(rd_resp_data == ref_block(blk), "R8 read data", rd_resp_data[63:0], ref_block(blk) & 128'hFFFF_FFFF_FFFF_FFFF);
      @(posedge clk);
      #1 rd_valid = 1'b0;
   endtask

   task automatic chk_log(input int i, input bit we, input int blk, input string req);
      check(log_n > i && log_we[i] == we && log_blk[i] == blk, req,
            (log_n > i) ? longint'(log_we[i]) * 256 + log_blk[i] : -1, longint'(we) * 256 + blk);
   endtask

   task automatic settle();
      frc = 1'b1;
      frc_val = 1'b1;
      repeat (25) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         mw[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
         rw[i] = mw[i];
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
      check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
      check(rd_resp_valid == 1'b0, "R1 rd_resp_valid", rd_resp_valid, 0);

      // R9: a write to the draining block opens a second entry
      frc = 1'b1; frc_val = 1'b0; log_n = 0;
      do_write(1, 0, 32'h1111_1111, 4'hF);
      repeat (3) @(negedge clk);
      do_write(1, 1, 32'h2222_2222, 4'hF);
      settle();
      check(log_n == 2, "R9 two drains", log_n, 2);
      chk_log(0, 1'b1, 1, "R9 first drain");
      chk_log(1, 1'b1, 1, "R9 second drain");
      check(log_mask[0] == 16'h000F, "R9 mask first", log_mask[0], 16'h000F);
      check(log_mask[1] == 16'h00F0, "R9 mask second", log_mask[1], 16'h00F0);

      // R2 / R3 / R4: fill, stall, merge
      frc = 1'b1; frc_val = 1'b0; log_n = 0;
      do_write(2, 0, 32'hB200_0000, 4'hF);
      do_write(3, 0, 32'hB300_0000, 4'hF);
      do_write(4, 3, 32'hB400_0000, 4'h1);
      do_write(5, 1, 32'hB500_0000, 4'h8);
      probe_write(6, 0, 1'b0, "R2 full stall");
      probe_write(2, 1, 1'b0, "R9 draining no merge");
      probe_write(3, 2, 1'b1, "R3 merge accepted when full");
      do_write(3, 2, 32'hCAFE_0001, 4'b0011);
      do_write(3, 2, 32'hBEEF_0000, 4'b1100);
      do_write(3, 0, 32'h0000_00EE, 4'b0001);
      settle();
      check(log_n == 4, "R4 one drain per entry", log_n, 4);
      chk_log(0, 1'b1, 2, "R4 order 0");
      chk_log(1, 1'b1, 3, "R4 order 1");
      chk_log(2, 1'b1, 4, "R4 order 2");
      chk_log(3, 1'b1, 5, "R4 order 3");
      check(log_mask[1] == 16'h0F0F, "R3 merged mask", log_mask[1], 16'h0F0F);
      check(log_mask[2] == 16'h1000, "R4 partial mask", log_mask[2], 16'h1000);

      // R6: read to a queued block waits for it
      frc = 1'b1; frc_val = 1'b0; log_n = 0;
      do_write(7, 0, 32'h7777_0000, 4'hF);
      do_write(8, 1, 32'h8888_0000, 4'hF);
      do_write(9, 2, 32'h9999_0000, 4'hF);
      repeat (3) @(negedge clk);
      fork
         do_read(9);
         begin repeat (4) @(negedge clk); frc_val = 1'b1; end
      join
      settle();
      chk_log(0, 1'b1, 7, "R6 seq 0");
      chk_log(1, 1'b1, 8, "R6 seq 1");
      chk_log(2, 1'b1, 9, "R6 seq 2");
      chk_log(3, 1'b0, 9, "R6 read last");

      // R5 / R7: clear read passes queued writes but not the drain in flight
      frc = 1'b1; frc_val = 1'b0; log_n = 0;
      do_write(10, 0, 32'hAAAA_0000, 4'hF);
      do_write(11, 0, 32'hBBBB_0000, 4'hF);
      do_write(12, 0, 32'hCCCC_0000, 4'hF);
      repeat (3) @(negedge clk);
      fork
         do_read(13);
         begin repeat (4) @(negedge clk); frc_val = 1'b1; end
      join
      settle();
      chk_log(0, 1'b1, 10, "R7 drain in flight first");
      chk_log(1, 1'b0, 13, "R5 read bypass");
      chk_log(2, 1'b1, 11, "R5 seq 2");
      chk_log(3, 1'b1, 12, "R5 seq 3");

      // random traffic against the reference image
      frc = 1'b0;
      for (int n = 0; n < 400; n++) begin
         int blk;
         blk = int'($urandom % 8);
         if (($urandom % 10) < 7)
            do_write(blk, int'($urandom % 4), $urandom, 4'($urandom % 15 + 1));
         else
            do_read(blk);
      end
      settle();
      for (int b = 0; b < 16; b++)
         check(mem_block(b) == ref_block(b), "R4 final memory image",
               mem_block(b) & 128'hFFFF_FFFF_FFFF_FFFF, ref_block(b) & 128'hFFFF_FFFF_FFFF_FFFF);

      summary();
      $finish;
   end
endmodule